// File: doc/BRIEF.md
# Clock-Synchronous Serial Slave Receiver

This block receives 8-bit words from an external master that owns the serial clock. The master changes the data line on falling clock edges. The receiver samples the data line on rising edges, least significant bit first. Both external lines are re-timed into the system clock domain, and rising serial-clock edges are found there. An active-low ready line tells the master when the slave will accept a word. The line drops when reception is switched on. It rises once the first bit of a word has arrived and drops again after the last bit.

A finished word is moved into a holding register and a buffer-full flag is raised. The flag also drives a receive-full interrupt request. Software can read the holding register while the next word is still being shifted in. If a new word finishes before the previous one was read, the new word overwrites the old one and a sticky overrun flag is set. The overrun flag drives an error interrupt request. The ready line is then held high and serial clock edges are ignored until the overwritten word is read.

Software reaches the block through a small register interface with three addresses: control, data and status.

Top module: `ssrx_top`

## Requirements
- R1: After reset, the ready output is high, both interrupt requests are low, reception is off and the data register reads 0. Writing 1 to bit 0 of the control register (address 0) turns reception on and drives the ready output low within one cycle.
- R2: Bits are captured on rising edges of the serial clock, least significant bit first. The eighth captured bit becomes bit 7 of the word.
- R3: When the eighth bit is captured, the word is copied into the data register (read at address 1). Bit 0 of the status register (address 2) is then set, and the receive-full interrupt request is raised.
- R4: A read of address 1 returns the stored word in the same cycle and clears the buffer-full flag and its interrupt request on the following cycle. A read part-way through a word does not disturb the word being received.
- R5: If a word completes while the buffer-full flag is still set, the data register takes the new word. Bit 1 of the status register (overrun) is then set, and the error interrupt request is raised.
- R6: The overrun flag stays set across later reads and received words. It clears only when software writes status address 2 with bit 1 equal to 0.
- R7: While reception is on, the ready output goes high after the first bit of a word and returns low after the eighth bit.
- R8: After an overrun, the ready output stays high and serial clock edges are ignored, until address 1 is read. After that read, the ready output is low and reception resumes.
- R9: Writing 0 to control bit 0 sets the ready output high and discards a partly received word. The data register, the buffer-full flag and the overrun flag keep their values.
- R10: Serial clock edges that arrive while reception is off shift nothing. A word sent after reception is turned on is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the master, idle high |
| ser_dat_i | input | 1 | Serial data from the master |
| rdy_n_o | output | 1 | Active-low ready to receive |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_full_o | output | 1 | Receive-full interrupt request |
| irq_err_o | output | 1 | Receive-error (overrun) interrupt request |

## Verification
A bit counter that is off by even one position shows up on the next word. That word appears rotated in the data register, and the ready line drops one bit early or one bit late, so the error is visible within a single frame. A suspend state that is wrongly held or wrongly released shows at once on the ready line. It also shows one word later as an unexpected overwrite, or as a missing one. Every one of the 256 byte values is passed through the receiver. Around these sweeps, short frame fragments exercise disable, overrun and mid-word reads.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned REG_W   = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_STAT = 2'd2
  } ssrx_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned STAT_FULL_BIT = 0;
  localparam int unsigned STAT_OVR_BIT  = 1;
endpackage

// File: rtl/ssrx_edge_sync.sv
module ssrx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk_i,
  input  logic ser_dat_i,
  output logic rise_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_q, clk_d;
  logic [STAGES-1:0] dat_q, dat_d;
  logic              prev_q, prev_d;

  always_comb begin
    clk_d  = {clk_q[STAGES-2:0], ser_clk_i};
    dat_d  = {dat_q[STAGES-2:0], ser_dat_i};
    prev_d = clk_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= '1;
      dat_q  <= '0;
      prev_q <= 1'b1;
    end else begin
      clk_q  <= clk_d;
      dat_q  <= dat_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = clk_q[STAGES-1] & ~prev_q;
  assign dat_o  = dat_q[STAGES-1];
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
  parameter int unsigned W = 8,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en_i,
  input  logic          clear_i,
  input  logic          din_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o,
  output logic [W-1:0]  word_o
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sreg_q, sreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == LAST);

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (shift_en_i) begin
      sreg_d = {din_i, sreg_q[W-1:1]};
      cnt_d  = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = shift_en_i & ~clear_i & last;
  assign word_o = sreg_d;
endmodule

// File: rtl/ssrx_status.sv
module ssrx_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr_i,
  input  logic         en_val_i,
  input  logic         rd_data_i,
  input  logic         ovr_clr_i,
  input  logic         done_i,
  input  logic [W-1:0] word_i,
  output logic         en_o,
  output logic         susp_o,
  output logic         full_o,
  output logic         ovr_o,
  output logic [W-1:0] data_o
);
  logic         en_q, en_d;
  logic         susp_q, susp_d;
  logic         full_q, full_d;
  logic         ovr_q, ovr_d;
  logic [W-1:0] data_q, data_d;
  logic         overrun;

  assign overrun = done_i & full_q & ~rd_data_i;

  always_comb begin
    en_d   = en_wr_i ? en_val_i : en_q;
    data_d = done_i ? word_i : data_q;

    full_d = full_q;
    if (done_i)         full_d = 1'b1;
    else if (rd_data_i) full_d = 1'b0;

    ovr_d = ovr_q;
    if (overrun)        ovr_d = 1'b1;
    else if (ovr_clr_i) ovr_d = 1'b0;

    susp_d = susp_q;
    if (overrun)        susp_d = 1'b1;
    else if (rd_data_i) susp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      en_q   <= en_d;
      susp_q <= susp_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      data_q <= data_d;
    end
  end

  assign en_o   = en_q;
  assign susp_o = susp_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign data_o = data_q;
endmodule

// File: rtl/ssrx_top.sv
module ssrx_top
  import ssrx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              rdy_n_o,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_full_o,
  output logic              irq_err_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               rise, sdat;
  logic               en, susp, full, ovr;
  logic               en_wr, rd_data, ovr_clr, shift_en, done;
  logic [CW-1:0]      cnt;
  logic [FRAME_W-1:0] word, data;
  logic               unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign en_wr    = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign ovr_clr  = reg_wr_i && (reg_addr_i == ADDR_STAT) && !reg_wdata_i[STAT_OVR_BIT];
  assign rd_data  = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign shift_en = rise && en && !susp;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:2];

  ssrx_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ser_clk_i (ser_clk_i),
    .ser_dat_i (ser_dat_i),
    .rise_o    (rise),
    .dat_o     (sdat)
  );

  ssrx_shifter #(.W(FRAME_W)) shift_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .shift_en_i (shift_en),
    .clear_i    (!en),
    .din_i      (sdat),
    .cnt_o      (cnt),
    .done_o     (done),
    .word_o     (word)
  );

  ssrx_status #(.W(FRAME_W)) stat_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en_wr_i   (en_wr),
    .en_val_i  (reg_wdata_i[CTRL_EN_BIT]),
    .rd_data_i (rd_data),
    .ovr_clr_i (ovr_clr),
    .done_i    (done),
    .word_i    (word),
    .en_o      (en),
    .susp_o    (susp),
    .full_o    (full),
    .ovr_o     (ovr),
    .data_o    (data)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o[CTRL_EN_BIT] = en;
      ADDR_DATA: reg_rdata_o = data;
      ADDR_STAT: begin
        reg_rdata_o[STAT_FULL_BIT] = full;
        reg_rdata_o[STAT_OVR_BIT]  = ovr;
      end
      default:   reg_rdata_o = '0;
    endcase
  end

  assign rdy_n_o    = !(en && !susp && (cnt == '0));
  assign irq_full_o = full;
  assign irq_err_o  = ovr;
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker #(
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          susp,
  input logic          done,
  input logic          full,
  input logic          ovr,
  input logic          rd_data,
  input logic          ovr_clr,
  input logic [CW-1:0] cnt,
  input logic          rdy_n
);
  AST_FULL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> full); // R3
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !full); // R4
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !rd_data) |=> (ovr && susp)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr); // R6
  AST_SUSP_HOLDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> rdy_n); // R8
  AST_SUSP_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && !rd_data) |=> $stable(cnt)); // R8
  AST_OFF_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R9
endmodule

bind ssrx_top ssrx_checker #(.CW(CW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .en      (en),
  .susp    (susp),
  .done    (done),
  .full    (full),
  .ovr     (ovr),
  .rd_data (rd_data),
  .ovr_clr (ovr_clr),
  .cnt     (cnt),
  .rdy_n   (rdy_n_o)
);

// File: tb/ssrx_top_tb_top.sv
module ssrx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b1;
  logic       ser_dat = 1'b0;
  logic       rdy_n;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_full, irq_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  ssrx_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk_i   (ser_clk),
    .ser_dat_i   (ser_dat),
    .rdy_n_o     (rdy_n),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_full_o  (irq_full),
    .irq_err_o   (irq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // one-cycle read strobe; returns value seen in that cycle
  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic send_bits(input logic [7:0] b, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      @(negedge clk);
      ser_clk = 1'b0; ser_dat = b[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdy_n after reset", rdy_n, 1);
    chk("R1 irq_full after reset", irq_full, 0);
    chk("R1 irq_err after reset", irq_err, 0);
    peek(2'd0, v); chk("R1 ctrl after reset", v, 0);
    peek(2'd1, v); chk("R1 data after reset", v, 0);

    // R10 edges while off are ignored
    send_bits(8'hFF, 0, 3);
    chk("R10 rdy_n stays high while off", rdy_n, 1);

    // R1 enable
    wr(2'd0, 8'h01);
    chk("R1 rdy_n low after enable", rdy_n, 0);
    peek(2'd0, v); chk("R1 ctrl reads enable", v, 1);

    send_bits(8'h5A, 0, 8);
    peek(2'd1, v); chk("R10 word intact after ignored edges", v, 8'h5A);
    rd(2'd1, v);

    // R2 R3 R4 R7 sweep of all byte values
    for (int b = 0; b < 256; b++) begin
      send_bits(8'(b), 0, 1);
      chk("R7 rdy_n high after first bit", rdy_n, 1);
      send_bits(8'(b), 1, 7);
      chk("R7 rdy_n low after last bit", rdy_n, 0);
      chk("R3 irq_full after word", irq_full, 1);
      peek(2'd2, v); chk("R3 status full bit", v, 1);
      rd(2'd1, v); chk("R2 received word", v, b);
      chk("R4 full cleared by read", irq_full, 0);
    end
    chk("R5 no overrun in sweep", irq_err, 0);

    // R4 read in the middle of the next word
    send_bits(8'h3C, 0, 8);
    send_bits(8'hA7, 0, 4);
    rd(2'd1, v); chk("R4 mid-word read value", v, 8'h3C);
    chk("R4 full cleared mid-word", irq_full, 0);
    send_bits(8'hA7, 4, 4);
    rd(2'd1, v); chk("R4 word after mid read", v, 8'hA7);
    chk("R4 no overrun after mid read", irq_err, 0);

    // R5 R8 overrun
    send_bits(8'h11, 0, 8);
    send_bits(8'h22, 0, 8);
    chk("R5 irq_err on overrun", irq_err, 1);
    peek(2'd2, v); chk("R5 status after overrun", v, 3);
    peek(2'd1, v); chk("R5 data overwritten", v, 8'h22);
    chk("R8 rdy_n high on overrun", rdy_n, 1);
    send_bits(8'h99, 0, 8);
    peek(2'd1, v); chk("R8 edges ignored while suspended", v, 8'h22);
    chk("R8 rdy_n held while suspended", rdy_n, 1);
    rd(2'd1, v); chk("R8 read overwritten word", v, 8'h22);
    chk("R8 rdy_n low after read", rdy_n, 0);
    send_bits(8'hC3, 0, 8);
    rd(2'd1, v); chk("R8 reception resumed", v, 8'hC3);

    // R6 sticky, cleared by writing 0
    chk("R6 overrun still set", irq_err, 1);
    wr(2'd2, 8'h02);
    chk("R6 write 1 does not clear", irq_err, 1);
    wr(2'd2, 8'h00);
    chk("R6 write 0 clears", irq_err, 0);

    // R9 disable mid-word
    send_bits(8'h4B, 0, 8);
    send_bits(8'hFF, 0, 3);
    wr(2'd0, 8'h00);
    chk("R9 rdy_n high after disable", rdy_n, 1);
    chk("R9 full kept", irq_full, 1);
    peek(2'd1, v); chk("R9 data kept", v, 8'h4B);
    wr(2'd0, 8'h01);
    chk("R9 rdy_n low after re-enable", rdy_n, 0);
    rd(2'd1, v);
    send_bits(8'h81, 0, 8);
    rd(2'd1, v); chk("R9 partial word discarded", v, 8'h81);

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule